// File: doc/BRIEF.md
# Segmented Lane Shift-Down Exchange

This block moves 32-bit values between the 32 lanes of a SIMD group in a single step. Every lane offers one value; one delta and one segment width, shared by the whole group, decide where each lane reads from. A lane picks up the value of the lane `delta` positions above it, but only inside its own segment. A lane whose source would fall past the top of its segment keeps its own value, and so does a lane whose source lane is inactive. Nothing wraps around and nothing is replaced with zero.

The group is cut into aligned, independent segments of 2, 4, 8, 16 or 32 lanes, selected by a 3-bit code. An unused code raises an error flag, and every lane then passes its own value through. The exchange itself is combinational. Results, the copied active mask and the error flag are registered, so a beat presented with `in_valid` comes out one clock later with `out_valid`. The copied mask tells the consumer which results belong to live lanes. An inactive requesting lane is still computed under the same rules.

Top module: `lane_shfl_dn`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high and low one clock after a cycle with `in_valid` low. While reset is asserted, `out_valid` and `out_err` are 0.
- R2: With a legal width W, a delta d in 1..W-1, (i mod W)+d < W and source lane i+d active, lane i's result is the input value of lane i+d.
- R3: When (i mod W)+d >= W, lane i's result is its own input value. This covers the top d lanes of every segment, with no wrap into the same segment or the next one.
- R4: When the source lane i+d is inactive (`in_active` bit clear), lane i's result is its own input value.
- R5: Width codes map as 1→2, 2→4, 3→8, 4→16 and 5→32 lanes per segment. Segments are aligned to multiples of their width.
- R6: Codes 0, 6 and 7 are illegal. For such a beat `out_err` is 1 alongside `out_valid`, and every lane returns its own value. `out_err` is 0 for legal beats and for idle cycles.
- R7: A delta of 0, or any delta >= W, returns every lane's own value.
- R8: `out_active` equals the `in_active` of the beat. Lanes whose own bit is clear still get a result under R2 to R4.
- R9: In a cycle without `in_valid`, `out_data` and `out_active` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Beat strobe |
| in_data | input | 1024 | Lane values; lane i at bits [32i+31:32i] |
| in_active | input | 32 | Live-lane mask, bit i for lane i |
| in_delta | input | 5 | Shift distance in lanes |
| in_wcode | input | 3 | Segment width code (R5, R6) |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | 1024 | Per-lane results, same packing as `in_data` |
| out_active | output | 32 | Copy of the beat's active mask |
| out_err | output | 1 | Illegal width code seen on this beat |

## Verification
The hardest case to reach is the one where the range rule and the activity rule interact near segment edges. Here a lane's source lies just inside its segment but is inactive, while its neighbour's source lies just outside the segment next to an active lane. Random masks over random deltas seldom land on that combination for every width. The stimulus therefore sweeps all eight width codes against deltas at 0, 1, W-1, W and 31, with sparse, dense, alternating and empty masks. Long random runs with idle gaps are added to exercise the hold rule.

// File: rtl/lane_shfl_pkg.sv
package lane_shfl_pkg;
  parameter int unsigned LANE_CNT   = 32;
  parameter int unsigned WORD_W     = 32;
  parameter int unsigned WCODE_BITS = 3;
endpackage

// File: rtl/shfl_wdec.sv
module shfl_wdec #(
  parameter int unsigned LANE_W  = 5,
  parameter int unsigned WCODE_W = 3
) (
  input  logic [WCODE_W-1:0] wcode,
  output logic [LANE_W:0]    seg_w,
  output logic               legal
);
  always_comb begin
    seg_w = '0;
    legal = 1'b0;
    if ((wcode != '0) && (wcode <= WCODE_W'(LANE_W))) begin
      legal = 1'b1;
      seg_w = (LANE_W+1)'(1) << wcode;
    end
  end
endmodule

// File: rtl/shfl_lane.sv
module shfl_lane #(
  parameter int unsigned LANES   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LANE_ID = 0,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES*DATA_W-1:0] data_all,
  input  logic [LANES-1:0]        act_all,
  input  logic [LANE_W-1:0]       delta,
  input  logic [LANE_W:0]         seg_w,
  input  logic                    legal,
  output logic [DATA_W-1:0]       res
);
  logic [LANE_W:0]   seg_off;
  logic [LANE_W:0]   reach;
  logic [LANE_W-1:0] src_lane;
  logic              in_seg;
  logic              take;

  always_comb begin
    // offset inside the segment; the sum never carries into a neighbour
    seg_off  = (LANE_W+1)'(LANE_ID) & (seg_w - (LANE_W+1)'(1));
    reach    = seg_off + {1'b0, delta};
    in_seg   = legal && (reach < seg_w);
    src_lane = LANE_W'(LANE_ID) + delta;
    take     = in_seg && act_all[src_lane];
    res      = take ? data_all[src_lane*DATA_W +: DATA_W]
                    : data_all[LANE_ID*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/lane_shfl_dn.sv
module lane_shfl_dn
  import lane_shfl_pkg::*;
#(
  parameter int unsigned LANES  = LANE_CNT,
  parameter int unsigned DATA_W = WORD_W,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned BUS_W  = LANES * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [BUS_W-1:0]      in_data,
  input  logic [LANES-1:0]      in_active,
  input  logic [LANE_W-1:0]     in_delta,
  input  logic [WCODE_BITS-1:0] in_wcode,
  output logic                  out_valid,
  output logic [BUS_W-1:0]      out_data,
  output logic [LANES-1:0]      out_active,
  output logic                  out_err
);
  logic [LANE_W:0]    seg_w;
  logic               legal;
  logic [BUS_W-1:0]   shf_data;

  logic               vld_d, vld_q;
  logic               err_d, err_q;
  logic [BUS_W-1:0]   dat_d, dat_q;
  logic [LANES-1:0]   act_d, act_q;

  shfl_wdec #(.LANE_W(LANE_W), .WCODE_W(WCODE_BITS)) u_wdec (
    .wcode (in_wcode),
    .seg_w (seg_w),
    .legal (legal)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    shfl_lane #(.LANES(LANES), .DATA_W(DATA_W), .LANE_ID(g)) u_lane (
      .data_all (in_data),
      .act_all  (in_active),
      .delta    (in_delta),
      .seg_w    (seg_w),
      .legal    (legal),
      .res      (shf_data[g*DATA_W +: DATA_W])
    );
  end

  // next state
  always_comb begin
    vld_d = in_valid;
    err_d = in_valid && !legal;
    dat_d = dat_q;
    act_d = act_q;
    if (in_valid) begin
      dat_d = shf_data;
      act_d = in_active;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  // datapath registers, enable folded into next state
  always_ff @(posedge clk) begin
    dat_q <= dat_d;
    act_q <= act_d;
  end

  assign out_valid  = vld_q;
  assign out_err    = err_q;
  assign out_data   = dat_q;
  assign out_active = act_q;

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_err);
  // R6
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |=> out_err && (out_data == $past(in_data)));
  // R7
  zero_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_delta == '0) |=> (out_data == $past(in_data)));
  // R4
  all_idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_active == '0) |=> (out_data == $past(in_data)));
  // R3
  top_lane_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[BUS_W-1 -: DATA_W] == $past(in_data[BUS_W-1 -: DATA_W])));
  // R8
  act_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_active == $past(in_active)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(out_active));
endmodule

// File: tb/sim_lane_shfl_dn.sv
`timescale 1ns/1ps
module sim_lane_shfl_dn;
  localparam int N  = 32;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    in_active = '0;
  logic [4:0]      in_delta = '0;
  logic [2:0]      in_wcode = '0;
  logic            out_valid;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    out_active;
  logic            out_err;

  always #2 clk = ~clk;

  lane_shfl_dn u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_active(in_active), .in_delta(in_delta), .in_wcode(in_wcode),
    .out_valid(out_valid), .out_data(out_data), .out_active(out_active),
    .out_err(out_err)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit          exp_vld = 1'b0;
  bit          exp_err = 1'b0;
  bit          have_data = 1'b0;
  logic [DW-1:0] exp_d [N];
  logic [N-1:0]  exp_act;
  string         exp_tag [N];

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: act=%0d cycles exp<=200000", cyc);
      finish_run();
    end
  end

  task automatic check_outputs();
    vectors++;
    if (out_valid !== exp_vld) begin
      miscompares++;
      $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, exp_vld);
    end
    if (out_err !== exp_err) begin
      miscompares++;
      $display("FAIL R6 out_err act=%0b exp=%0b", out_err, exp_err);
    end
    if (have_data) begin
      if (out_active !== exp_act) begin
        miscompares++;
        $display("FAIL R8 out_active act=%h exp=%h", out_active, exp_act);
      end
      for (int i = 0; i < N; i++) begin
        if (out_data[i*DW +: DW] !== exp_d[i]) begin
          miscompares++;
          $display("FAIL %s lane %0d act=%h exp=%h", exp_tag[i], i,
                   out_data[i*DW +: DW], exp_d[i]);
        end
      end
    end
  endtask

  // behavioural reference of one beat
  task automatic model(input bit v, input logic [N*DW-1:0] d, input logic [N-1:0] a,
                       input int dl, input int wc);
    bit ok;
    int w;
    exp_vld = v;
    ok = (wc >= 1) && (wc <= 5);
    exp_err = v && !ok;
    if (!v) begin
      for (int i = 0; i < N; i++) exp_tag[i] = "R9 hold";
      return;
    end
    have_data = 1'b1;
    exp_act = a;
    w = 1 << wc;
    for (int i = 0; i < N; i++) begin
      exp_d[i] = d[i*DW +: DW];
      // R8: the requesting lane's own active bit plays no part
      if (!ok)                    exp_tag[i] = "R6 illegal code";
      else if (dl == 0 || dl >= w) exp_tag[i] = "R7 null delta";
      else if ((i % w) + dl >= w)  exp_tag[i] = "R3 past segment";
      else if (!a[i+dl])           exp_tag[i] = "R4 idle source";
      else begin
        exp_tag[i] = "R2,R5 shifted";
        exp_d[i] = d[(i+dl)*DW +: DW];
      end
    end
  endtask

  task automatic step(input bit v, input logic [N*DW-1:0] d, input logic [N-1:0] a,
                      input int dl, input int wc);
    @(negedge clk);
    check_outputs();
    in_valid  = v;
    in_data   = d;
    in_active = a;
    in_delta  = 5'(dl);
    in_wcode  = 3'(wc);
    model(v, d, a, dl, wc);
  endtask

  function automatic logic [N*DW-1:0] rnd_bus();
    logic [N*DW-1:0] b;
    for (int i = 0; i < N; i++) b[i*DW +: DW] = $urandom;
    return b;
  endfunction

  logic [N-1:0] masks [6];
  int deltas [9];

  initial begin
    logic [N*DW-1:0] ids;
    masks[0] = '1;          masks[1] = '0;
    masks[2] = 32'h5555_5555; masks[3] = 32'hAAAA_AAAA;
    masks[4] = 32'hF0F0_0F0F; masks[5] = 32'h8001_0001;
    deltas[0] = 0; deltas[1] = 1; deltas[2] = 2; deltas[3] = 3; deltas[4] = 7;
    deltas[5] = 8; deltas[6] = 15; deltas[7] = 16; deltas[8] = 31;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0 || out_err !== 1'b0) begin
        miscompares++;
        $display("FAIL R1 reset act=%0b/%0b exp=0/0", out_valid, out_err);
      end
    end
    rst_n = 1'b1;

    // R2: lane ids, delta 2, width 8
    for (int i = 0; i < N; i++) ids[i*DW +: DW] = DW'(i);
    step(1, ids, '1, 2, 3);
    step(0, rnd_bus(), '0, 5, 3);
    step(1, ids, '1, 1, 5);

    // R3/R4/R5/R6/R7 sweep over codes, deltas and masks
    for (int wc = 0; wc < 8; wc++)
      for (int k = 0; k < 9; k++)
        for (int m = 0; m < 6; m++) begin
          step(1, rnd_bus(), masks[m], deltas[k], wc);
          if (((k + m) % 4) == 0) step(1, rnd_bus(), masks[m], (1 << wc) - 1, wc);
        end

    // random beats with idle gaps (R9)
    for (int t = 0; t < 3000; t++)
      step(($urandom % 4) != 0, rnd_bus(), N'($urandom), $urandom % 32, $urandom % 8);

    step(0, '0, '0, 0, 0);
    step(0, '0, '0, 0, 0);
    @(negedge clk);
    check_outputs();
    finish_run();
  end
endmodule